// File: doc/BRIEF.md
# Staggered Double-Pumped Integer Adder

This unit is a short integer pipeline that runs on a fast clock, at twice the core rate. It splits a 32-bit add, subtract or bitwise operation into two 16-bit slices. The low slice is computed on the first fast edge after an operation is accepted. The high slice follows on the next edge and takes the low slice's registered carry. On the third edge a separate stage derives the condition flags from the finished word.

Each of the three products leaves the block with its own valid pulse and a copy of the operation's tag. A dependent operation can therefore start as soon as the low half it needs exists. It does not have to wait for the full word or for the flags.

Forwarding is chosen per operand. When a forward select is set, the operand is replaced by the result of the most recently accepted operation. The low slice of the new operation takes the previous low half. One edge later, its high slice takes the previous high half. Because of this, back-to-back dependent operations issue one per fast cycle without stalling. Multiply, long shifts and scheduling are handled elsewhere.

Top module: `staggered_add_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `lo_valid`, `hi_valid` and `flg_valid` are all low in the following cycle.
- R2: An operation accepted (`in_valid` high) at edge k drives `lo_valid` high after edge k. In that cycle `lo_result` holds bits 15:0 of the operation's 32-bit result and `lo_tag` holds its tag.
- R3: The same operation drives `hi_valid` high after edge k+1. `hi_result` then holds bits 31:16 of the result, including the carry out of the low slice, and `hi_tag` holds its tag.
- R4: The same operation drives `flg_valid` high after edge k+2. `flg_tag` holds its tag and `flags` holds {zero, sign, carry, overflow} in bits 3 down to 0. Zero means the 32-bit result is zero, and sign is result bit 31.
- R5: Opcode encoding on `in_op`: 0 is A+B and 1 is A-B. For subtract, the carry flag is the carry out of A + ~B + 1, so carry=1 means no borrow.
- R6: Opcode 2 is A AND B, 3 is A OR B and 4 is A XOR B. For these three, carry and overflow are 0.
- R7: For add and subtract, overflow is set exactly when the result of the signed 32-bit operation does not fit in 32 bits.
- R8: A new operation may be accepted on every fast cycle. Each stage carries its own operation's result and tag independently.
- R9: When `fwd_a` (or `fwd_b`) is high with `in_valid`, operand A (or B) is replaced by the full 32-bit result of the most recently accepted operation. This holds however many idle cycles lie between the two operations.
- R10: Opcodes 5, 6 and 7 behave exactly as add.
- R11: A cycle with `in_valid` low produces no output valid pulse. Its operand, opcode, tag and forward inputs have no effect on any later result, including forwarded ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the core rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_tag | input | 4 | Destination tag |
| fwd_a | input | 1 | Take operand A from the previous result |
| fwd_b | input | 1 | Take operand B from the previous result |
| lo_valid | output | 1 | Low half available |
| lo_result | output | 16 | Result bits 15:0 |
| lo_tag | output | 4 | Tag of the low half |
| hi_valid | output | 1 | High half available |
| hi_result | output | 16 | Result bits 31:16 |
| hi_tag | output | 4 | Tag of the high half |
| flg_valid | output | 1 | Flags available |
| flags | output | 4 | {zero, sign, carry, overflow} |
| flg_tag | output | 4 | Tag of the flags |

## Verification
The hardest case to reach is a forwarded high half that meets a carry crossing the slice boundary. For that to happen, the previous operation's high slice must be written on the same edge that the dependent operation's low slice is computed. The stimulus builds this with chains of back-to-back forwarded operations on low halves near 0xFFFF, with forwarding on A, on B and on both. It then places idle cycles carrying garbage operands and tags before a forwarded operation, to show that forwarding still reaches back to the last accepted result.

// File: rtl/stag_add_pkg.sv
// Shared opcode values, decoded control and flag layout for the staggered adder.
// Assumes a 3-bit opcode; unknown codes fall back to add.
package stag_add_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_ADD = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB = 3'd1;
    localparam logic [OP_W-1:0] OP_AND = 3'd2;
    localparam logic [OP_W-1:0] OP_OR  = 3'd3;
    localparam logic [OP_W-1:0] OP_XOR = 3'd4;

    typedef enum logic [1:0] {LF_AND = 2'd0, LF_OR = 2'd1, LF_XOR = 2'd2} lfn_e;

    typedef struct packed {
        logic arith;     // adder path (add/sub) versus bitwise path
        logic invert_b;  // subtract: invert B and inject carry-in of one
        lfn_e lfn;       // bitwise function when arith is low
    } dec_t;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } flags_t;

    // Turn an opcode into slice controls; reserved codes act as add.
    function automatic dec_t decode_op(input logic [OP_W-1:0] op);
        dec_t d;
        d = '{arith: 1'b1, invert_b: 1'b0, lfn: LF_AND};
        case (op)
            OP_SUB: d.invert_b = 1'b1;
            OP_AND: begin d.arith = 1'b0; d.lfn = LF_AND; end
            OP_OR:  begin d.arith = 1'b0; d.lfn = LF_OR;  end
            OP_XOR: begin d.arith = 1'b0; d.lfn = LF_XOR; end
            default: d.arith = 1'b1;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/stag_lo_slice.sv
// Stage 1: computes the low slice of an accepted operation and registers its
// carry, the untouched high operand halves and the controls for stage 2.
// Assumes forwarding picks the low half of the last accepted operation,
// which this stage itself holds.
module stag_lo_slice
    import stag_add_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [HALF_W-1:0] in_a_lo,
    input  logic [HALF_W-1:0] in_b_lo,
    input  logic [HALF_W-1:0] in_a_hi,
    input  logic [HALF_W-1:0] in_b_hi,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              fwd_a,
    input  logic              fwd_b,
    output logic              lo_valid,
    output logic [HALF_W-1:0] lo_result,
    output logic [TAG_W-1:0]  lo_tag,
    output logic              lo_carry,
    output logic [HALF_W-1:0] a_hi_q,
    output logic [HALF_W-1:0] b_hi_q,
    output logic [OP_W-1:0]   op_q,
    output logic              fwd_a_q,
    output logic              fwd_b_q
);
    dec_t              dec;
    logic [HALF_W-1:0] a_sel, b_sel, b_eff, logic_res, res_d;
    logic [HALF_W:0]   sum_ext;
    logic              cout_d;

    // Select operands, then form the low sum or the bitwise value.
    always_comb begin
        dec     = decode_op(in_op);
        a_sel   = fwd_a ? lo_result : in_a_lo;
        b_sel   = fwd_b ? lo_result : in_b_lo;
        b_eff   = dec.invert_b ? ~b_sel : b_sel;
        sum_ext = {1'b0, a_sel} + {1'b0, b_eff} + {{HALF_W{1'b0}}, dec.invert_b};
        case (dec.lfn)
            LF_OR:   logic_res = a_sel | b_sel;
            LF_XOR:  logic_res = a_sel ^ b_sel;
            default: logic_res = a_sel & b_sel;
        endcase
        res_d  = dec.arith ? sum_ext[HALF_W-1:0] : logic_res;
        cout_d = dec.arith & sum_ext[HALF_W];
    end

    // Valid pulse for the low half.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_valid <= 1'b0;
        else        lo_valid <= in_valid;
    end

    // Stage-1 payload; held while idle so forwarding sees the last result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_result <= '0;
            lo_tag    <= '0;
            lo_carry  <= 1'b0;
            a_hi_q    <= '0;
            b_hi_q    <= '0;
            op_q      <= OP_ADD;
            fwd_a_q   <= 1'b0;
            fwd_b_q   <= 1'b0;
        end else if (in_valid) begin
            lo_result <= res_d;
            lo_tag    <= in_tag;
            lo_carry  <= cout_d;
            a_hi_q    <= in_a_hi;
            b_hi_q    <= in_b_hi;
            op_q      <= in_op;
            fwd_a_q   <= fwd_a;
            fwd_b_q   <= fwd_b;
        end
    end

    a_r2_lo_tag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (lo_valid && lo_tag == $past(in_tag)));
    a_r11_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !lo_valid);
    a_r11_idle_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lo_result));
endmodule

// File: rtl/stag_hi_slice.sv
// Stage 2: computes the high slice using the registered low carry and passes
// the operand signs and the low half on for flag generation.
// Assumes forwarding picks the high half of the last accepted operation,
// which this stage holds when the dependent operation reaches it.
module stag_hi_slice
    import stag_add_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [HALF_W-1:0] s1_lo,
    input  logic [TAG_W-1:0]  s1_tag,
    input  logic              s1_carry,
    input  logic [HALF_W-1:0] s1_a_hi,
    input  logic [HALF_W-1:0] s1_b_hi,
    input  logic [OP_W-1:0]   s1_op,
    input  logic              s1_fwd_a,
    input  logic              s1_fwd_b,
    output logic              hi_valid,
    output logic [HALF_W-1:0] hi_result,
    output logic [TAG_W-1:0]  hi_tag,
    output logic [HALF_W-1:0] lo_copy,
    output logic              carry_q,
    output logic              sign_a_q,
    output logic              sign_b_q,
    output logic              arith_q
);
    dec_t              dec;
    logic [HALF_W-1:0] a_sel, b_sel, b_eff, logic_res, res_d;
    logic [HALF_W:0]   sum_ext;

    // High operands, optionally replaced by the previous high half.
    always_comb begin
        dec     = decode_op(s1_op);
        a_sel   = s1_fwd_a ? hi_result : s1_a_hi;
        b_sel   = s1_fwd_b ? hi_result : s1_b_hi;
        b_eff   = dec.invert_b ? ~b_sel : b_sel;
        sum_ext = {1'b0, a_sel} + {1'b0, b_eff} + {{HALF_W{1'b0}}, s1_carry};
        case (dec.lfn)
            LF_OR:   logic_res = a_sel | b_sel;
            LF_XOR:  logic_res = a_sel ^ b_sel;
            default: logic_res = a_sel & b_sel;
        endcase
        res_d = dec.arith ? sum_ext[HALF_W-1:0] : logic_res;
    end

    // Valid pulse for the high half.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_valid <= 1'b0;
        else        hi_valid <= s1_valid;
    end

    // Stage-2 payload; held while idle for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_result <= '0;
            hi_tag    <= '0;
            lo_copy   <= '0;
            carry_q   <= 1'b0;
            sign_a_q  <= 1'b0;
            sign_b_q  <= 1'b0;
            arith_q   <= 1'b0;
        end else if (s1_valid) begin
            hi_result <= res_d;
            hi_tag    <= s1_tag;
            lo_copy   <= s1_lo;
            carry_q   <= dec.arith & sum_ext[HALF_W];
            sign_a_q  <= a_sel[HALF_W-1];
            sign_b_q  <= b_eff[HALF_W-1];
            arith_q   <= dec.arith;
        end
    end

    a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (hi_valid && hi_tag == $past(s1_tag)));
    a_r9_hi_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(hi_result));
endmodule

// File: rtl/stag_flag_stage.sv
// Stage 3: derives zero, sign, carry and overflow from the finished word.
// Assumes stage 2 supplies the final carry and the effective operand signs.
module stag_flag_stage
    import stag_add_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_valid,
    input  logic [HALF_W-1:0] s2_hi,
    input  logic [HALF_W-1:0] s2_lo,
    input  logic [TAG_W-1:0]  s2_tag,
    input  logic              s2_carry,
    input  logic              s2_sign_a,
    input  logic              s2_sign_b,
    input  logic              s2_arith,
    output logic              flg_valid,
    output flags_t            flags,
    output logic [TAG_W-1:0]  flg_tag
);
    flags_t f_d;

    // Flag logic over the whole word.
    always_comb begin
        f_d.zero  = (s2_hi == '0) && (s2_lo == '0);
        f_d.sign  = s2_hi[HALF_W-1];
        f_d.carry = s2_arith & s2_carry;
        f_d.ovf   = s2_arith & (s2_sign_a == s2_sign_b) & (s2_hi[HALF_W-1] != s2_sign_a);
    end

    // Flag register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_valid <= 1'b0;
            flags     <= '0;
            flg_tag   <= '0;
        end else begin
            flg_valid <= s2_valid;
            if (s2_valid) begin
                flags   <= f_d;
                flg_tag <= s2_tag;
            end
        end
    end

    a_r4_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> (flg_valid && flg_tag == $past(s2_tag)));
    a_r6_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_arith) |=> (!flags.carry && !flags.ovf));
    a_r4_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> (flags.sign == $past(s2_hi[HALF_W-1])));
endmodule

// File: rtl/staggered_add_unit.sv
// Top: three-stage staggered adder on the fast clock. Low half after one
// edge, high half after two, flags after three; one operation per cycle.
// Assumes DATA_W is even; forwarding always refers to the last accepted op.
module staggered_add_unit
    import stag_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              fwd_a,
    input  logic              fwd_b,
    output logic              lo_valid,
    output logic [HALF_W-1:0] lo_result,
    output logic [TAG_W-1:0]  lo_tag,
    output logic              hi_valid,
    output logic [HALF_W-1:0] hi_result,
    output logic [TAG_W-1:0]  hi_tag,
    output logic              flg_valid,
    output logic [3:0]        flags,
    output logic [TAG_W-1:0]  flg_tag
);
    logic              s1_carry, s1_fwd_a, s1_fwd_b;
    logic [HALF_W-1:0] s1_a_hi, s1_b_hi;
    logic [OP_W-1:0]   s1_op;
    logic [HALF_W-1:0] s2_lo;
    logic              s2_carry, s2_sign_a, s2_sign_b, s2_arith;
    flags_t            flags_s;

    stag_lo_slice #(.HALF_W(HALF_W), .TAG_W(TAG_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a_lo(in_a[HALF_W-1:0]), .in_b_lo(in_b[HALF_W-1:0]),
        .in_a_hi(in_a[DATA_W-1:HALF_W]), .in_b_hi(in_b[DATA_W-1:HALF_W]),
        .in_tag(in_tag), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .lo_valid(lo_valid), .lo_result(lo_result), .lo_tag(lo_tag),
        .lo_carry(s1_carry), .a_hi_q(s1_a_hi), .b_hi_q(s1_b_hi),
        .op_q(s1_op), .fwd_a_q(s1_fwd_a), .fwd_b_q(s1_fwd_b)
    );

    stag_hi_slice #(.HALF_W(HALF_W), .TAG_W(TAG_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .s1_valid(lo_valid), .s1_lo(lo_result),
        .s1_tag(lo_tag), .s1_carry(s1_carry), .s1_a_hi(s1_a_hi),
        .s1_b_hi(s1_b_hi), .s1_op(s1_op), .s1_fwd_a(s1_fwd_a),
        .s1_fwd_b(s1_fwd_b), .hi_valid(hi_valid), .hi_result(hi_result),
        .hi_tag(hi_tag), .lo_copy(s2_lo), .carry_q(s2_carry),
        .sign_a_q(s2_sign_a), .sign_b_q(s2_sign_b), .arith_q(s2_arith)
    );

    stag_flag_stage #(.HALF_W(HALF_W), .TAG_W(TAG_W)) u_flg (
        .clk(clk), .rst_n(rst_n), .s2_valid(hi_valid), .s2_hi(hi_result),
        .s2_lo(s2_lo), .s2_tag(hi_tag), .s2_carry(s2_carry),
        .s2_sign_a(s2_sign_a), .s2_sign_b(s2_sign_b), .s2_arith(s2_arith),
        .flg_valid(flg_valid), .flags(flags_s), .flg_tag(flg_tag)
    );

    assign flags = flags_s;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!lo_valid && !hi_valid && !flg_valid));
    a_r8_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
        lo_valid |=> hi_valid ##1 flg_valid);
endmodule

// File: tb/staggered_add_unit_test.sv
// Scoreboard bench: the driver pushes expected low, high and flag items;
// a monitor pops and compares them when each valid pulse appears.
module staggered_add_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, fwd_a, fwd_b;
    logic [2:0]  in_op;
    logic [31:0] in_a, in_b;
    logic [3:0]  in_tag;
    logic        lo_valid, hi_valid, flg_valid;
    logic [15:0] lo_result, hi_result;
    logic [3:0]  lo_tag, hi_tag, flg_tag, flags;

    int checks = 0;
    int failures = 0;

    logic [19:0] q_lo[$], q_hi[$];   // {tag, half}
    logic [7:0]  q_fl[$];            // {tag, flags}
    string       r_lo[$], r_hi[$], r_fl[$];
    logic [31:0] last_res = '0;

    always #2.5 clk = ~clk;  // 200 MHz

    staggered_add_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_tag(in_tag), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .lo_valid(lo_valid), .lo_result(lo_result), .lo_tag(lo_tag),
        .hi_valid(hi_valid), .hi_result(hi_result), .hi_tag(hi_tag),
        .flg_valid(flg_valid), .flags(flags), .flg_tag(flg_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at a negedge; a valid op gets its expected items queued.
    task automatic issue(input bit v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] tag,
                         input bit fa, input bit fb, input string req);
        logic [31:0] ea, eb, r;
        logic [32:0] s;
        logic        c, ov;
        in_valid = v; in_op = op; in_a = a; in_b = b; in_tag = tag;
        fwd_a = fa; fwd_b = fb;
        if (v) begin
            ea = fa ? last_res : a;
            eb = fb ? last_res : b;
            c = 1'b0; ov = 1'b0;
            case (op)
                3'd1: begin
                    s = {1'b0, ea} + {1'b0, ~eb} + 33'd1;
                    r = s[31:0]; c = s[32];
                    ov = (ea[31] != eb[31]) && (r[31] != ea[31]);
                end
                3'd2: r = ea & eb;
                3'd3: r = ea | eb;
                3'd4: r = ea ^ eb;
                default: begin
                    s = {1'b0, ea} + {1'b0, eb};
                    r = s[31:0]; c = s[32];
                    ov = (ea[31] == eb[31]) && (r[31] != ea[31]);
                end
            endcase
            q_lo.push_back({tag, r[15:0]});  r_lo.push_back(req);
            q_hi.push_back({tag, r[31:16]}); r_hi.push_back(req);
            q_fl.push_back({tag, (r == 32'd0), r[31], c, ov}); r_fl.push_back(req);
            last_res = r;
        end
        @(negedge clk);
    endtask

    // Monitor: compare each valid output against the head of its queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (lo_valid) begin
                if (q_lo.size() == 0) check(0, "R11", "unexpected lo_valid", 32'd1, 32'd0);
                else begin
                    logic [19:0] e; string rq;
                    e = q_lo.pop_front(); rq = r_lo.pop_front();
                    check(lo_result == e[15:0], {rq, "/R2"}, "lo_result", {16'd0, lo_result}, {16'd0, e[15:0]});
                    check(lo_tag == e[19:16], "R2", "lo_tag", {28'd0, lo_tag}, {28'd0, e[19:16]});
                end
            end
            if (hi_valid) begin
                if (q_hi.size() == 0) check(0, "R11", "unexpected hi_valid", 32'd1, 32'd0);
                else begin
                    logic [19:0] e; string rq;
                    e = q_hi.pop_front(); rq = r_hi.pop_front();
                    check(hi_result == e[15:0], {rq, "/R3"}, "hi_result", {16'd0, hi_result}, {16'd0, e[15:0]});
                    check(hi_tag == e[19:16], "R3", "hi_tag", {28'd0, hi_tag}, {28'd0, e[19:16]});
                end
            end
            if (flg_valid) begin
                if (q_fl.size() == 0) check(0, "R11", "unexpected flg_valid", 32'd1, 32'd0);
                else begin
                    logic [7:0] e; string rq;
                    e = q_fl.pop_front(); rq = r_fl.pop_front();
                    check(flags == e[3:0], {rq, "/R4"}, "flags", {28'd0, flags}, {28'd0, e[3:0]});
                    check(flg_tag == e[7:4], "R4", "flg_tag", {28'd0, flg_tag}, {28'd0, e[7:4]});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1; in_op = 3'd0; in_a = '1; in_b = '1; in_tag = 4'hF;
        fwd_a = 1'b0; fwd_b = 1'b0;
        repeat (2) @(negedge clk);
        // R1: valids stay low under reset even with in_valid high
        check(!lo_valid && !hi_valid && !flg_valid, "R1", "valids in reset",
              {29'd0, lo_valid, hi_valid, flg_valid}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Basic ops, carry across the slice boundary (R2, R3)
        issue(1, 3'd0, 32'h0000_0005, 32'h0000_0007, 4'd1, 0, 0, "R2");
        issue(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 4'd2, 0, 0, "R3");
        issue(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 4'd3, 0, 0, "R4");
        // Subtract: borrow, equal operands (R5)
        issue(1, 3'd1, 32'h0000_0003, 32'h0000_0005, 4'd4, 0, 0, "R5");
        issue(1, 3'd1, 32'h1234_5678, 32'h1234_5678, 4'd5, 0, 0, "R5");
        issue(1, 3'd1, 32'h0001_0000, 32'h0000_0001, 4'd6, 0, 0, "R5");
        // Signed overflow (R7)
        issue(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 4'd7, 0, 0, "R7");
        issue(1, 3'd1, 32'h8000_0000, 32'h0000_0001, 4'd8, 0, 0, "R7");
        issue(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 4'd9, 0, 0, "R7");
        // Bitwise ops (R6)
        issue(1, 3'd2, 32'hF0F0_FFFF, 32'hFFFF_0F0F, 4'd10, 0, 0, "R6");
        issue(1, 3'd3, 32'h8000_0000, 32'h0000_0001, 4'd11, 0, 0, "R6");
        issue(1, 3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd12, 0, 0, "R6");
        // Reserved opcodes act as add (R10)
        issue(1, 3'd5, 32'h0000_FFFF, 32'h0000_FFFF, 4'd13, 0, 0, "R10");
        issue(1, 3'd7, 32'h7FFF_8000, 32'h0000_8000, 4'd14, 0, 0, "R10");
        issue(0, 3'd0, 32'h0, 32'h0, 4'd0, 0, 0, "R11");
        repeat (4) issue(0, 3'd1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 4'd15, 1, 1, "R11");

        // Back-to-back forwarding chain near the slice carry (R8, R9)
        issue(1, 3'd0, 32'h0000_FFF0, 32'h0000_0008, 4'd1, 0, 0, "R8");
        issue(1, 3'd0, 32'h0, 32'h0000_0008, 4'd2, 1, 0, "R9");
        issue(1, 3'd0, 32'h0001_0000, 32'h0, 4'd3, 0, 1, "R9");
        issue(1, 3'd0, 32'h0, 32'h0, 4'd4, 1, 1, "R9");
        issue(1, 3'd1, 32'h0, 32'h0000_0001, 4'd5, 1, 0, "R9");
        issue(1, 3'd1, 32'h0, 32'h0, 4'd6, 1, 1, "R9");
        // Idle cycles with garbage, then forward (R11, R9)
        issue(1, 3'd0, 32'h1234_FFFF, 32'h0000_0001, 4'd7, 0, 0, "R9");
        repeat (3) issue(0, 3'd4, 32'hFFFF_FFFF, 32'h5555_5555, 4'd9, 1, 1, "R11");
        issue(1, 3'd0, 32'h0, 32'h0000_0000, 4'd8, 1, 0, "R11");

        // Random mix of ops, gaps and forwarding (R8)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 5 == 0) ra[15:0] = 16'hFFFF;
            issue(($urandom % 4) != 0, 3'($urandom % 8), ra, rb, 4'($urandom),
                  ($urandom % 3) == 0, ($urandom % 4) == 0, "R8");
        end
        repeat (6) issue(0, 3'd0, 32'h0, 32'h0, 4'd0, 0, 0, "R8");
        check(q_lo.size() == 0 && q_hi.size() == 0 && q_fl.size() == 0, "R8",
              "results outstanding", q_lo.size() + q_hi.size() + q_fl.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule